// File: doc/BRIEF.md
# Dibit Baud Clock Elastic Interface

This block connects a two-bit-per-symbol line data path to an external device that supplies its own baud clocks. On the send side the device presents a dibit together with a transmit baud clock. The block samples both with its fast internal clock, finds the chosen edge of the baud clock, and pushes the dibit into an eight-entry elastic buffer. The symbol logic drains that buffer on its own symbol tick. On the receive side each symbol tick pushes a core dibit into a second eight-entry buffer. The block pops it onto the external dibit output on the chosen edge of the receive baud clock.

A small control register sets the active edge for each direction and holds a two-bit interface mode. Only mode 01 (parallel slave) moves data. The register also has a pointer-stagger bit. While that bit is high, both buffers sit half full and no data moves. Clearing the bit after the clocks are frequency locked starts the buffers from the centre, which gives the most tolerance to phase wander. Two sticky flags record a dropped transmit dibit and a receive underflow.

Top module: `dbi_baud_if`

## Requirements
- R1: After reset the control readback is 8'h00, both dibit outputs are 2'b00, the core valid pulse is low and both sticky flags are low.
- R2: A write strobe loads the 5-bit control value, which takes effect in the next cycle. Field positions are: bit 4 transmit falling edge, bit 3 receive falling edge, bit 2 stagger, bits 1:0 mode. The mode code 2'b01 is parallel slave. The readback is that value with bits 7:5 reading zero.
- R3: In parallel slave mode with stagger clear, dibits are sampled at the chosen transmit baud edge: rising when bit 4 is 0, falling when it is 1. On each symbol tick with data present, the oldest dibit appears on the core dibit output with a one-cycle valid pulse. Order is first in, first out.
- R4: In the same mode, each symbol tick stores the core receive dibit. The external dibit output takes the oldest stored dibit at the chosen receive baud edge: rising when bit 3 is 0, falling when it is 1. Order is first in, first out.
- R5: A baud clock level and the transmit dibit are both captured at clock edge k. The resulting buffer action happens at clock edge k+2. Two detected edges of one baud clock are never in adjacent cycles.
- R6: While stagger is set in parallel slave mode, neither buffer accepts or delivers data. After stagger clears, each buffer holds exactly four entries of 2'b00.
- R7: The transmit buffer holds 8 dibits. A dibit sampled while it is full is dropped and sets the sticky transmit overflow flag.
- R8: A symbol tick while the transmit buffer is empty leaves the valid pulse low and the core dibit output unchanged.
- R9: A receive baud edge while the receive buffer is empty leaves the external dibit output unchanged and sets the sticky receive underflow flag.
- R10: A symbol tick while the receive buffer holds 8 dibits drops the new dibit and leaves the stored ones intact.
- R11: In any mode other than 2'b01, baud edges and symbol ticks move no data and change no output or flag. The stagger bit is ignored.
- R12: When a write and a read of one buffer fall in the same cycle, full and empty are judged on the occupancy at the start of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal fast clock, also the symbol clock domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 5 | Control value to load |
| ctrl_rdata_o | output | 8 | Control register readback |
| tx_baud_clk_i | input | 1 | External transmit baud clock |
| tx_dibit_i | input | 2 | External transmit dibit |
| sym_tick_i | input | 1 | Symbol-rate enable of the internal domain |
| core_tx_dibit_o | output | 2 | Dibit delivered to the symbol logic |
| core_tx_valid_o | output | 1 | One-cycle pulse when a dibit is delivered |
| core_rx_dibit_i | input | 2 | Dibit produced by the symbol logic |
| rx_baud_clk_i | input | 1 | External receive baud clock |
| rx_dibit_o | output | 2 | External receive dibit |
| tx_ovf_o | output | 1 | Sticky transmit overflow flag |
| rx_unf_o | output | 1 | Sticky receive underflow flag |

## Verification
Two things can happen to one buffer in the same cycle: a write from a detected baud edge or a symbol tick, and a read from a symbol tick or a baud edge. This matters most when the buffer is exactly full or exactly empty. The closing phase drives both baud clocks and the symbol tick from coin flips, and an earlier phase first drives both buffers to their limits, so these coincidences occur many times. The queue-based reference decides full and empty from its occupancy before either operation, and every output is compared against it on every cycle.

// File: rtl/dbi_pkg.sv
package dbi_pkg;

    localparam int DIBIT_W = 2;
    localparam int CTRL_W  = 5;

    typedef enum logic [1:0] {
        MODE_ALT0           = 2'b00,
        MODE_PARALLEL_SLAVE = 2'b01,
        MODE_ALT2           = 2'b10,
        MODE_ALT3           = 2'b11
    } if_mode_e;

    // Control register, bit 4 down to bit 0.
    typedef struct packed {
        logic     tx_fall;
        logic     rx_fall;
        logic     stagger;
        if_mode_e mode;
    } ctrl_t;

endpackage

// File: rtl/dbi_edge_detect.sv
module dbi_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic fall_sel_i,
    output logic edge_o
);

    typedef struct packed {
        logic [2:0] sh;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[1:0], bclk_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign edge_o = fall_sel_i ? (st_q.sh[2] & ~st_q.sh[1])
                               : (st_q.sh[1] & ~st_q.sh[2]);

    // R5: one baud clock never yields edges in adjacent cycles
    assert_edge_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_o && $stable(fall_sel_i)) |=> !edge_o);

endmodule

// File: rtl/dbi_fifo.sv
module dbi_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stagger_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         rd_en_i,
    output logic [W-1:0] rd_data_o,
    output logic         rd_ok_o,
    output logic         full_o,
    output logic         empty_o
);

    localparam int AW   = $clog2(DEPTH);
    localparam int PW   = AW + 1;
    localparam int HALF = DEPTH / 2;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wptr;
        logic [PW-1:0]           rptr;
    } fifo_st_t;

    fifo_st_t    st_d, st_q;
    logic [PW-1:0] level;
    logic        wr_ok;

    assign level     = st_q.wptr - st_q.rptr;
    assign full_o    = (level == PW'(DEPTH));
    assign empty_o   = (level == '0);
    assign wr_ok     = wr_en_i & ~full_o & ~stagger_i;
    assign rd_ok_o   = rd_en_i & ~empty_o & ~stagger_i;
    assign rd_data_o = st_q.mem[st_q.rptr[AW-1:0]];

    always_comb begin
        st_d = st_q;
        if (stagger_i) begin
            st_d.mem  = '0;
            st_d.rptr = '0;
            st_d.wptr = PW'(HALF);
        end else begin
            if (wr_ok) begin
                st_d.mem[st_q.wptr[AW-1:0]] = wr_data_i;
                st_d.wptr = st_q.wptr + PW'(1);
            end
            if (rd_ok_o) begin
                st_d.rptr = st_q.rptr + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: occupancy never exceeds the depth
    assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        level <= PW'(DEPTH));

    // R6: the stagger bit leaves the buffer exactly half full
    assert_stagger_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stagger_i |=> (level == PW'(HALF)));

    // R7: a write into a full buffer with no read leaves it full
    assert_drop_keeps_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && wr_en_i && !rd_en_i && !stagger_i) |=> full_o);

    // R12: a read with a write in the same cycle on an empty buffer delivers nothing
    assert_empty_no_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && wr_en_i && !stagger_i) |=> !empty_o);

endmodule

// File: rtl/dbi_baud_if.sv
module dbi_baud_if
    import dbi_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_wr_i,
    input  logic [CTRL_W-1:0]  ctrl_wdata_i,
    output logic [7:0]         ctrl_rdata_o,
    input  logic               tx_baud_clk_i,
    input  logic [DIBIT_W-1:0] tx_dibit_i,
    input  logic               sym_tick_i,
    output logic [DIBIT_W-1:0] core_tx_dibit_o,
    output logic               core_tx_valid_o,
    input  logic [DIBIT_W-1:0] core_rx_dibit_i,
    input  logic               rx_baud_clk_i,
    output logic [DIBIT_W-1:0] rx_dibit_o,
    output logic               tx_ovf_o,
    output logic               rx_unf_o
);

    localparam int PAD_W = 8 - CTRL_W;

    typedef struct packed {
        ctrl_t              ctrl;
        logic [DIBIT_W-1:0] tx_pipe1;
        logic [DIBIT_W-1:0] tx_pipe2;
        logic [DIBIT_W-1:0] core_tx;
        logic               core_vld;
        logic [DIBIT_W-1:0] rx_out;
        logic               tx_ovf;
        logic               rx_unf;
    } top_st_t;

    top_st_t st_d, st_q;

    logic ps_mode, active, stag;
    logic tx_edge, rx_edge;
    logic tx_wr, tx_rd, tx_rd_ok, tx_full, tx_empty;
    logic rx_wr, rx_rd, rx_rd_ok, rx_full, rx_empty;
    logic [DIBIT_W-1:0] tx_head, rx_head;

    assign ps_mode = (st_q.ctrl.mode == MODE_PARALLEL_SLAVE);
    assign stag    = ps_mode & st_q.ctrl.stagger;
    assign active  = ps_mode & ~st_q.ctrl.stagger;

    dbi_edge_detect u_tx_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_i     (tx_baud_clk_i),
        .fall_sel_i (st_q.ctrl.tx_fall),
        .edge_o     (tx_edge)
    );

    dbi_edge_detect u_rx_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_i     (rx_baud_clk_i),
        .fall_sel_i (st_q.ctrl.rx_fall),
        .edge_o     (rx_edge)
    );

    assign tx_wr = active & tx_edge;
    assign tx_rd = active & sym_tick_i;
    assign rx_wr = active & sym_tick_i;
    assign rx_rd = active & rx_edge;

    dbi_fifo #(.DEPTH(DEPTH), .W(DIBIT_W)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .stagger_i (stag),
        .wr_en_i   (tx_wr),
        .wr_data_i (st_q.tx_pipe2),
        .rd_en_i   (tx_rd),
        .rd_data_o (tx_head),
        .rd_ok_o   (tx_rd_ok),
        .full_o    (tx_full),
        .empty_o   (tx_empty)
    );

    dbi_fifo #(.DEPTH(DEPTH), .W(DIBIT_W)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .stagger_i (stag),
        .wr_en_i   (rx_wr),
        .wr_data_i (core_rx_dibit_i),
        .rd_en_i   (rx_rd),
        .rd_data_o (rx_head),
        .rd_ok_o   (rx_rd_ok),
        .full_o    (rx_full),
        .empty_o   (rx_empty)
    );

    always_comb begin
        st_d          = st_q;
        st_d.tx_pipe1 = tx_dibit_i;
        st_d.tx_pipe2 = st_q.tx_pipe1;
        st_d.core_vld = tx_rd_ok;
        if (ctrl_wr_i) begin
            st_d.ctrl = ctrl_t'(ctrl_wdata_i);
        end
        if (tx_rd_ok) begin
            st_d.core_tx = tx_head;
        end
        if (tx_wr && tx_full) begin
            st_d.tx_ovf = 1'b1;
        end
        if (rx_rd_ok) begin
            st_d.rx_out = rx_head;
        end
        if (rx_rd && rx_empty) begin
            st_d.rx_unf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_rdata_o    = {{PAD_W{1'b0}}, st_q.ctrl};
    assign core_tx_dibit_o = st_q.core_tx;
    assign core_tx_valid_o = st_q.core_vld;
    assign rx_dibit_o      = st_q.rx_out;
    assign tx_ovf_o        = st_q.tx_ovf;
    assign rx_unf_o        = st_q.rx_unf;

    // R3: a delivery pulse only follows a symbol tick
    assert_valid_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        core_tx_valid_o |-> $past(sym_tick_i));

    // R8: a tick on an empty transmit buffer delivers nothing
    assert_empty_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !stag) |=> !core_tx_valid_o);

    // R7: overflow flag is sticky
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf_o |=> tx_ovf_o);

    // R9: underflow flag is sticky
    assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_unf_o |=> rx_unf_o);

    // R9: the external receive dibit only moves on a successful pop
    assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_rd_ok |=> $stable(rx_dibit_o));

    // R10: a tick on a full receive buffer without a pop keeps it full
    assert_rx_full_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && rx_wr && !rx_rd) |=> rx_full);

    // R11: outside parallel slave mode nothing is delivered
    assert_idle_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ps_mode |=> !core_tx_valid_o);

endmodule

// File: tb/test_dbi_baud_if.sv
module test_dbi_baud_if;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ctrl_wr;
    logic [4:0] ctrl_wdata;
    logic [7:0] ctrl_rdata;
    logic       tx_baud, rx_baud, sym_tick;
    logic [1:0] tx_dibit, core_tx_dibit, core_rx_dibit, rx_dibit;
    logic       core_tx_valid, tx_ovf, rx_unf;

    dbi_baud_if i_dbi_baud_if (
        .clk             (clk),
        .rst_n           (rst_n),
        .ctrl_wr_i       (ctrl_wr),
        .ctrl_wdata_i    (ctrl_wdata),
        .ctrl_rdata_o    (ctrl_rdata),
        .tx_baud_clk_i   (tx_baud),
        .tx_dibit_i      (tx_dibit),
        .sym_tick_i      (sym_tick),
        .core_tx_dibit_o (core_tx_dibit),
        .core_tx_valid_o (core_tx_valid),
        .core_rx_dibit_i (core_rx_dibit),
        .rx_baud_clk_i   (rx_baud),
        .rx_dibit_o      (rx_dibit),
        .tx_ovf_o        (tx_ovf),
        .rx_unf_o        (rx_unf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    string phase  = "R1";

    // reference model state
    logic [4:0] m_ctrl;
    logic       mt1, mt2, mt3, mr1, mr2, mr3;
    logic [1:0] mq1, mq2;
    logic [1:0] txq[$];
    logic [1:0] rxq[$];
    logic [1:0] m_core, m_rq;
    logic       m_vld, m_ovf, m_unf;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; mt1 = 0; mt2 = 0; mt3 = 0; mr1 = 0; mr2 = 0; mr3 = 0;
            mq1 = '0; mq2 = '0; txq.delete(); rxq.delete();
            m_core = '0; m_rq = '0; m_vld = 0; m_ovf = 0; m_unf = 0;
        end else begin
            bit te, re, ps;
            int tn, rn;
            te = m_ctrl[4] ? (mt3 & ~mt2) : (mt2 & ~mt3);
            re = m_ctrl[3] ? (mr3 & ~mr2) : (mr2 & ~mr3);
            ps = (m_ctrl[1:0] == 2'b01);
            m_vld = 0;
            if (ps && m_ctrl[2]) begin
                txq = '{2'b00, 2'b00, 2'b00, 2'b00};
                rxq = '{2'b00, 2'b00, 2'b00, 2'b00};
            end else if (ps) begin
                tn = txq.size();
                rn = rxq.size();
                if (sym_tick && tn > 0) begin m_core = txq.pop_front(); m_vld = 1; end
                if (te) begin if (tn < 8) txq.push_back(mq2); else m_ovf = 1; end
                if (sym_tick && rn < 8) rxq.push_back(core_rx_dibit);
                if (re) begin if (rn > 0) m_rq = rxq.pop_front(); else m_unf = 1; end
            end
            mt3 = mt2; mt2 = mt1; mt1 = tx_baud;
            mr3 = mr2; mr2 = mr1; mr1 = rx_baud;
            mq2 = mq1; mq1 = tx_dibit;
            if (ctrl_wr) m_ctrl = ctrl_wdata;
        end
    end

    task automatic chk(string what, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL [%s] %s: got %h expected %h", phase, what, got, exp);
        end
    endtask

    task automatic compare_all();
        chk("ctrl readback", ctrl_rdata, {3'b000, m_ctrl});
        chk("core tx dibit", {6'd0, core_tx_dibit}, {6'd0, m_core});
        chk("core tx valid", {7'd0, core_tx_valid}, {7'd0, m_vld});
        chk("rx dibit", {6'd0, rx_dibit}, {6'd0, m_rq});
        chk("tx overflow", {7'd0, tx_ovf}, {7'd0, m_ovf});
        chk("rx underflow", {7'd0, rx_unf}, {7'd0, m_unf});
    endtask

    int         cyc = 0;
    int         tick_m = 0, txb_m = 0, rxb_m = 0;
    bit         pend = 0;
    logic [4:0] pval = '0;

    task automatic step();
        @(negedge clk);
        compare_all();
        cyc++;
        ctrl_wr    = pend;
        ctrl_wdata = pval;
        pend       = 0;
        tx_dibit      = 2'($urandom);
        core_rx_dibit = 2'($urandom);
        case (txb_m)
            1:       tx_baud = ((cyc / 3) % 2) == 1;
            2:       tx_baud = 1'($urandom);
            default: ;
        endcase
        case (rxb_m)
            1:       rx_baud = (((cyc + 1) / 3) % 2) == 1;
            2:       rx_baud = 1'($urandom);
            default: ;
        endcase
        case (tick_m)
            1:       sym_tick = (cyc % 6) == 0;
            2:       sym_tick = 1'($urandom);
            3:       sym_tick = 1'b1;
            default: sym_tick = 1'b0;
        endcase
    endtask

    task automatic run(int n);
        repeat (n) step();
    endtask

    task automatic wctrl(logic [4:0] v);
        pend = 1;
        pval = v;
        step();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL [watchdog] run did not finish: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 0; ctrl_wr = 0; ctrl_wdata = '0; tx_baud = 0; rx_baud = 0;
        sym_tick = 0; tx_dibit = '0; core_rx_dibit = '0;
        repeat (3) begin @(negedge clk); compare_all(); end
        rst_n = 1;
        @(negedge clk);
        // R1: reset values at the ports
        chk("R1 ctrl after reset", ctrl_rdata, 8'h00);
        chk("R1 valid after reset", {7'd0, core_tx_valid}, 8'h00);
        chk("R1 rx dibit after reset", {6'd0, rx_dibit}, 8'h00);
        chk("R1 flags after reset", {6'd0, tx_ovf, rx_unf}, 8'h00);

        phase = "R2";
        wctrl(5'h1F); run(4);
        chk("R2 unused bits read zero", ctrl_rdata, 8'h1F);

        phase = "R6 R11";
        txb_m = 1; rxb_m = 1; tick_m = 1;
        wctrl(5'h05); run(20);
        phase = "R3 R4 R5 R6";
        wctrl(5'h01); run(300);

        phase = "R3 R4 falling edges";
        wctrl(5'h1D); run(10);
        wctrl(5'h19); run(300);

        phase = "R7 R9";
        tick_m = 0; run(120);
        chk("R7 overflow flag set", {7'd0, tx_ovf}, 8'h01);
        chk("R9 underflow flag set", {7'd0, rx_unf}, 8'h01);

        phase = "R8";
        txb_m = 0; tick_m = 1; run(120);

        phase = "R10";
        rxb_m = 0; tick_m = 3; run(40);
        rxb_m = 1; run(80);

        phase = "R11";
        txb_m = 2; rxb_m = 2; tick_m = 2;
        wctrl(5'h0A); run(150);
        wctrl(5'h1B); run(50);

        phase = "R12";
        wctrl(5'h09); run(3000);
        wctrl(5'h01); run(3000);

        summary();
        $finish;
    end

endmodule